// File: doc/BRIEF.md
# Latched/Registered Bidirectional Bus Transceiver

This block connects two 16-bit buses, side A and side B, with one independent storage path for each direction. Each path has three controls of its own: a high-impedance request, a pass control and a capture strobe. When the pass control is high the path is transparent and its store follows the source bus. When the pass control is low the store only loads on a low-to-high transition of the strobe. Otherwise it holds its value.

Real tri-state pins are replaced by a data output and an active-high drive flag for each side. A chip-level pad or mux stage decides what to do with them. The whole block runs on one system clock. The strobes and all other controls are sampled on its rising edge. Every output is a register, so each output shows the inputs sampled at the previous system clock edge.

When both sides are driven at once, a registered contention flag is raised so the surrounding logic can see that the bus is being fought over.

Top module: `bidir_hold_xcvr`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both stores clear to zero, both drive flags and `contention` go low, and each strobe's history is set high. A strobe that is already high when reset is released is therefore not a rising edge.
- R2: Each side's drive flag equals the inverse of its direction's `*_hiz` input sampled at the previous edge, whatever the other inputs are. `b_drive` follows `ab_hiz` and `a_drive` follows `ba_hiz`. The high-impedance request does not stop the store from updating.
- R3: With `ab_pass` high at an edge, `b_out` after that edge equals the `a_in` value sampled at that edge (transparent mode, one cycle of latency).
- R4: With `ab_pass` low, an edge at which `ab_strobe` is sampled 1 while it was sampled 0 at the previous edge loads `a_in` into the store, and the value appears on `b_out`.
- R5: With `ab_pass` low and `ab_strobe` sampled low, `b_out` keeps its value while `a_in` changes.
- R6: With `ab_pass` low and `ab_strobe` held high, `b_out` keeps its value. This includes the case where the strobe was already high when the pass control fell, and the case where it was high across reset release.
- R7: When the pass control falls, the store keeps the last value it took while transparent.
- R8: The B-to-A direction behaves as in R3 to R7, using `b_in`, `ba_pass`, `ba_strobe` and output `a_out`, and is independent of the A-to-B controls.
- R9: `contention` is high after an edge exactly when both `ab_hiz` and `ba_hiz` were sampled low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Data arriving from side A |
| b_in | input | W | Data arriving from side B |
| ab_hiz | input | 1 | High: side B not driven |
| ab_pass | input | 1 | High: A-to-B path transparent; low: strobe-captured |
| ab_strobe | input | 1 | A-to-B capture strobe (rising transition loads) |
| ba_hiz | input | 1 | High: side A not driven |
| ba_pass | input | 1 | High: B-to-A path transparent; low: strobe-captured |
| ba_strobe | input | 1 | B-to-A capture strobe (rising transition loads) |
| b_out | output | W | Data toward side B |
| b_drive | output | 1 | High when `b_out` should be placed on side B |
| a_out | output | W | Data toward side A |
| a_drive | output | 1 | High when `a_out` should be placed on side A |
| contention | output | 1 | Both sides driven at once |

## Verification
Each direction is first run transparently while its source bus changes value every cycle. A stuck or late path shows up as a lag against the reference model. The strobe is then toggled with fresh data between toggles, which separates edge capture from level capture. The strobe is also held low and held high while the data keeps moving, including across reset release and at the moment the pass control falls, where a design that treats a high level as an edge would load wrong data. The high-impedance requests are swept through all four combinations, which checks that the drive flags are independent of the stores and that the contention flag is raised only when both sides drive.

// File: rtl/bidir_hold_xcvr_pkg.sv
package bidir_hold_xcvr_pkg;
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;
  localparam int unsigned NUM_DIRS = 2;

  typedef enum logic [1:0] {
    LANE_HOLD    = 2'd0,
    LANE_FLOW    = 2'd1,
    LANE_CAPTURE = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic hist_q;

  // history starts high so a level already high after reset is no edge
  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b1;
    else     hist_q <= level;
  end

  assign rise = level & ~hist_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import bidir_hold_xcvr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         hiz,
  input  logic         pass,
  input  logic         strobe,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic       strobe_rise;
  lane_mode_e mode;
  logic [W-1:0] store_q;
  logic         drive_q;

  xcvr_rise_det u_rise (
    .clk   (clk),
    .rst   (rst),
    .level (strobe),
    .rise  (strobe_rise)
  );

  always_comb begin
    if (pass)             mode = LANE_FLOW;
    else if (strobe_rise) mode = LANE_CAPTURE;
    else                  mode = LANE_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      drive_q <= 1'b0;
    end else begin
      case (mode)
        LANE_FLOW, LANE_CAPTURE: store_q <= din;
        default:                 store_q <= store_q;
      endcase
      drive_q <= ~hiz;
    end
  end

  assign dout  = store_q;
  assign drive = drive_q;
endmodule

// File: rtl/bidir_hold_xcvr.sv
module bidir_hold_xcvr
  import bidir_hold_xcvr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_hiz,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ba_hiz,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic         contention
);
  logic [NUM_DIRS-1:0][W-1:0] src, dst;
  logic [NUM_DIRS-1:0]        hiz, pass, strobe, drv;
  logic                       contention_q;

  assign src[DIR_AB]    = a_in;
  assign src[DIR_BA]    = b_in;
  assign hiz[DIR_AB]    = ab_hiz;
  assign hiz[DIR_BA]    = ba_hiz;
  assign pass[DIR_AB]   = ab_pass;
  assign pass[DIR_BA]   = ba_pass;
  assign strobe[DIR_AB] = ab_strobe;
  assign strobe[DIR_BA] = ba_strobe;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .din    (src[d]),
      .hiz    (hiz[d]),
      .pass   (pass[d]),
      .strobe (strobe[d]),
      .dout   (dst[d]),
      .drive  (drv[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) contention_q <= 1'b0;
    else     contention_q <= ~|hiz;
  end

  assign b_out      = dst[DIR_AB];
  assign b_drive    = drv[DIR_AB];
  assign a_out      = dst[DIR_BA];
  assign a_drive    = drv[DIR_BA];
  assign contention = contention_q;
endmodule

// File: rtl/bidir_hold_xcvr_chk.sv
module bidir_hold_xcvr_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_hiz,
  input logic         ab_pass,
  input logic         ab_strobe,
  input logic         ba_hiz,
  input logic         ba_pass,
  input logic         ba_strobe,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic         contention
);
  // R2
  b_drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b_drive == !$past(ab_hiz)));
  // R2
  a_drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_drive == !$past(ba_hiz)));
  // R3
  ab_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ab_pass)) |-> (b_out == $past(a_in)));
  // R8
  ba_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ba_pass)) |-> (a_out == $past(b_in)));
  // R4
  ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(ab_pass) && $past(ab_strobe)
     && !$past(ab_strobe, 2)) |-> (b_out == $past(a_in)));
  // R5
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(ab_pass)
     && !($past(ab_strobe) && !$past(ab_strobe, 2))) |-> $stable(b_out));
  // R8
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(ba_pass)
     && !($past(ba_strobe) && !$past(ba_strobe, 2))) |-> $stable(a_out));
  // R9
  contention_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (contention == (!$past(ab_hiz) && !$past(ba_hiz))));
endmodule

bind bidir_hold_xcvr bidir_hold_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
  .ab_hiz(ab_hiz), .ab_pass(ab_pass), .ab_strobe(ab_strobe),
  .ba_hiz(ba_hiz), .ba_pass(ba_pass), .ba_strobe(ba_strobe),
  .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
  .contention(contention)
);

// File: tb/bidir_hold_xcvr_test.sv
`timescale 1ns/1ps
module bidir_hold_xcvr_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_hiz = 1'b1, ab_pass = 1'b0, ab_strobe = 1'b1;
  logic ba_hiz = 1'b1, ba_pass = 1'b0, ba_strobe = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive, contention;

  always #2 clk = ~clk;

  bidir_hold_xcvr #(.W(W)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_hiz(ab_hiz), .ab_pass(ab_pass), .ab_strobe(ab_strobe),
    .ba_hiz(ba_hiz), .ba_pass(ba_pass), .ba_strobe(ba_strobe),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
    .contention(contention)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference state: index 0 = A-to-B, 1 = B-to-A
  int m_out[2];
  bit m_drv[2];
  bit m_prev[2];
  bit m_cont;

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    int  src[2];
    bit  pas[2], stb[2], hz[2];
    @(posedge clk);
    #1;
    src[0] = int'(a_in); src[1] = int'(b_in);
    pas[0] = ab_pass;    pas[1] = ba_pass;
    stb[0] = ab_strobe;  stb[1] = ba_strobe;
    hz[0]  = ab_hiz;     hz[1]  = ba_hiz;
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        m_out[d] = 0; m_drv[d] = 0; m_prev[d] = 1;
      end
      m_cont = 0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (pas[d] || (stb[d] && !m_prev[d])) m_out[d] = src[d];
        m_drv[d]  = !hz[d];
        m_prev[d] = stb[d];
      end
      m_cont = !hz[0] && !hz[1];
    end
    cmp("b_out", int'(b_out), m_out[0]);
    cmp("a_out", int'(a_out), m_out[1]);
    cmp("b_drive", int'(b_drive), int'(m_drv[0]));
    cmp("a_drive", int'(a_drive), int'(m_drv[1]));
    cmp("contention", int'(contention), int'(m_cont));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset with strobes high
    tag = "R1";
    a_in = 16'hDEAD; b_in = 16'hBEEF;
    tick(); tick();
    rst = 1'b0;
    // R6: strobe high across reset release, no capture
    tag = "R6";
    tick();
    a_in = 16'h1111; tick(); tick();
    // R3: transparent, data moving every cycle
    tag = "R3";
    ab_pass = 1'b1; ab_hiz = 1'b0;
    for (int i = 0; i < 6; i++) begin
      a_in = 16'h0101 * (i + 3); tick();
    end
    // R7 / R6: pass falls while strobe already high
    tag = "R7";
    ab_pass = 1'b0; a_in = 16'hA5A5; tick();
    tag = "R6";
    for (int i = 0; i < 4; i++) begin
      a_in = 16'h3C00 + i; tick();
    end
    // R4: strobe edges capture
    tag = "R4";
    for (int i = 0; i < 4; i++) begin
      ab_strobe = 1'b0; a_in = 16'h7700 + i; tick();
      ab_strobe = 1'b1; a_in = 16'h8800 + i; tick();
    end
    // R5: strobe low, data moving
    tag = "R5";
    ab_strobe = 1'b0;
    for (int i = 0; i < 4; i++) begin
      a_in = 16'hC0DE ^ i; tick();
    end
    // R2: hiz sweep with transparent path
    tag = "R2";
    ab_pass = 1'b1;
    ab_hiz = 1'b1; a_in = 16'hFACE; tick();
    ab_hiz = 1'b0; a_in = 16'h0F0F; tick();
    ab_hiz = 1'b1; ab_pass = 1'b0; ab_strobe = 1'b1; a_in = 16'h1234; tick();
    // R8: B-to-A direction, A-to-B parked
    tag = "R8";
    ab_pass = 1'b0; ab_strobe = 1'b0; ab_hiz = 1'b1;
    ba_hiz = 1'b0; ba_pass = 1'b1;
    for (int i = 0; i < 4; i++) begin
      b_in = 16'h5000 + 16'h0111 * i; a_in = 16'hFFFF - i; tick();
    end
    ba_pass = 1'b0; b_in = 16'h9999; tick();
    b_in = 16'h4444; tick();
    ba_strobe = 1'b0; tick();
    ba_strobe = 1'b1; b_in = 16'h6161; tick();
    b_in = 16'h2222; tick();
    // R9: contention over all hiz combinations
    tag = "R9";
    for (int i = 0; i < 4; i++) begin
      ab_hiz = i[0]; ba_hiz = i[1]; tick();
    end
    ab_hiz = 1'b0; ba_hiz = 1'b0; tick();
    // R1: reset mid-run clears everything
    tag = "R1";
    rst = 1'b1; tick();
    rst = 1'b0; ab_hiz = 1'b1; ba_hiz = 1'b1; tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule